// File: doc/BRIEF.md
# Microsequencer Maintenance Access Port

This block gives a host a small register window into a microprogrammed controller. Through four register addresses the host can hold the controller in reset, let it run freely, or advance it by one step. It can also load the program counter and reach the 16-bit control store at the word the program counter selects. The store is never addressed directly. The host first writes the PC register, whose enable bits decide whether later writes to the instruction window reach the store. It then reads or writes that window.

Each stored word carries an even-parity bit. Every read of the instruction window checks that bit and keeps the result in a flag, which the diagnostic register reports. The controller's datapath is reduced to a stub that only advances the program counter. Host reads are registered and are valid on the cycle after the read strobe.

Register map (2-bit `reg_addr`): 0 = maintenance, 1 = PC, 2 = instruction window, 3 = diagnostic.

Top module: `useq_maint_port`

## Requirements
- R1: After reset, `reg_rdata` is 0, and reads of the PC and diagnostic registers return 0 (PC 0, not running, parity flag clear).
- R2: A PC-register write latches the control bits: bit 15 instruction-window enable, bit 14 store-write enable, bit 12 auto-increment. It loads the PC from bits [10:0] (the PC value modulo the store depth) only when bit 13 is set. Without bit 13 the PC is unchanged.
- R3: A write to the instruction window stores the data at the current PC only when store-write enable is latched. Otherwise the write leaves the store unchanged.
- R4: A read of any address returns its value on `reg_rdata` one cycle after the strobe, and `reg_rdata` holds until the next read. A read of the instruction window returns the store word at the current PC.
- R5: Each stored word keeps an even-parity bit. Every instruction-window read updates the parity-error flag (diagnostic bit 14), and the flag is 0 after reading any word that the port wrote.
- R6: A maintenance write with bit 1 (start) and bit 2 (single-cycle) both set performs one step. It advances the PC by one when auto-increment is latched and leaves it unchanged otherwise. The running flag stays 0.
- R7: A maintenance write with start set and single-cycle clear sets the running flag. While running, the PC advances by one on every clock, wrapping from depth-1 to 0. A maintenance write with start clear stops it, and that write's edge still advances the PC.
- R8: Maintenance bit 0 (reset) is a level. While it is held, the running flag is 0, the PC is 0, and PC loads and start requests have no effect.
- R9: A read of the PC register returns {window enable, store-write enable, 0, auto-increment, PC[11:0]}. A read of the maintenance register returns bit 1 = running and bit 0 = reset held.
- R10: A read of the diagnostic register returns bit 15 = running, bit 14 = parity error, bits [11:0] = PC, and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |

## Verification
A write takes effect at the clock edge where its strobe is high. Read data is due one cycle after the read strobe, so the bench drives on falling edges and samples on the falling edge after the strobe. When the controller runs, the start edge does not advance the PC. Each later edge does, including the edge of the stop write. The bench therefore expects N+1 increments for N idle cycles between the two writes. Reset is released two edges after `rst_n` rises, and the bench waits past that before its first access.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] RA_MAINT = 2'd0;
  localparam logic [REG_AW-1:0] RA_PC    = 2'd1;
  localparam logic [REG_AW-1:0] RA_IR    = 2'd2;
  localparam logic [REG_AW-1:0] RA_DIAG  = 2'd3;

  // maintenance register bits
  localparam int MB_RESET  = 0;
  localparam int MB_START  = 1;
  localparam int MB_SINGLE = 2;

  // PC register bits
  localparam int PB_AUTO = 12;
  localparam int PB_LOAD = 13;
  localparam int PB_MSEN = 14;
  localparam int PB_IREN = 15;

  // diagnostic register bits
  localparam int DB_PERR = 14;
  localparam int DB_RUN  = 15;

  typedef struct packed {
    logic ir_en;
    logic ms_en;
    logic auto_inc;
  } pc_ctl_t;
endpackage

// File: rtl/useq_cstore.sv
module useq_cstore #(
  parameter int DATA_W   = 16,
  parameter int CS_DEPTH = 2048,
  localparam int CS_AW   = $clog2(CS_DEPTH)
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              we,
  input  logic [CS_AW-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [CS_AW-1:0]  raddr,
  output logic [DATA_W-1:0] rword,
  output logic              perr
);
  logic [DATA_W:0]   mem [CS_DEPTH];
  logic [DATA_W:0]   rd_ent;
  logic [DATA_W-1:0] word_d, word_q;
  logic              perr_d, perr_q;

  // storage: parity bit on top makes each entry even
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {^wdata, wdata};
  end

  always_comb begin
    rd_ent = mem[raddr];
    word_d = word_q;
    perr_d = perr_q;
    if (re) begin
      word_d = rd_ent[DATA_W-1:0];
      perr_d = ^rd_ent;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      word_q <= '0;
      perr_q <= 1'b0;
    end else begin
      word_q <= word_d;
      perr_q <= perr_d;
    end
  end

  assign rword = word_q;
  assign perr  = perr_q;
endmodule

// File: rtl/useq_pc_ctl.sv
module useq_pc_ctl
  import useq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int PC_W     = 12,
  parameter int CS_DEPTH = 2048,
  localparam int CS_AW   = $clog2(CS_DEPTH)
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              maint_wr,
  input  logic              pc_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              auto_inc,
  output logic [PC_W-1:0]   pc,
  output logic              running,
  output logic              hold
);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(CS_DEPTH - 1);

  logic [PC_W-1:0] pc_d, pc_q, pc_inc, pc_ld;
  logic            run_d, run_q, hold_d, hold_q;
  logic            step;

  assign pc_inc = (pc_q == PC_LAST) ? '0 : pc_q + 1'b1;
  assign pc_ld  = PC_W'(wdata[CS_AW-1:0]);
  assign step   = maint_wr && wdata[MB_START] && wdata[MB_SINGLE];

  always_comb begin
    pc_d   = pc_q;
    run_d  = run_q;
    hold_d = hold_q;
    if (maint_wr) hold_d = wdata[MB_RESET];
    if (hold_d) begin
      pc_d  = '0;
      run_d = 1'b0;
    end else begin
      if (maint_wr) run_d = wdata[MB_START] && !wdata[MB_SINGLE];
      if (pc_wr && wdata[PB_LOAD])          pc_d = pc_ld;
      else if (run_q || (step && auto_inc)) pc_d = pc_inc;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pc_q   <= '0;
      run_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      run_q  <= run_d;
      hold_q <= hold_d;
    end
  end

  assign pc      = pc_q;
  assign running = run_q;
  assign hold    = hold_q;
endmodule

// File: rtl/useq_regif.sv
module useq_regif
  import useq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PC_W   = 12
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [PC_W-1:0]   pc,
  input  logic              running,
  input  logic              hold,
  input  logic              perr,
  input  logic [DATA_W-1:0] cram_word,
  output logic              maint_wr,
  output logic              pc_wr,
  output logic              cs_we,
  output logic              cs_re,
  output pc_ctl_t           ctl,
  output logic [DATA_W-1:0] reg_rdata
);
  pc_ctl_t           ctl_d, ctl_q;
  logic [DATA_W-1:0] snap_d, snap_q;
  logic              isir_d, isir_q;

  assign maint_wr = reg_wr && (reg_addr == RA_MAINT);
  assign pc_wr    = reg_wr && (reg_addr == RA_PC);
  assign cs_we    = reg_wr && (reg_addr == RA_IR) && ctl_q.ms_en;
  assign cs_re    = reg_rd && (reg_addr == RA_IR);

  always_comb begin
    ctl_d = ctl_q;
    if (pc_wr) begin
      ctl_d.ir_en    = reg_wdata[PB_IREN];
      ctl_d.ms_en    = reg_wdata[PB_MSEN];
      ctl_d.auto_inc = reg_wdata[PB_AUTO];
    end
  end

  always_comb begin
    snap_d = snap_q;
    isir_d = isir_q;
    if (reg_rd) begin
      isir_d = (reg_addr == RA_IR);
      unique case (reg_addr)
        RA_MAINT: snap_d = DATA_W'({running, hold});
        RA_PC:    snap_d = DATA_W'({ctl_q.ir_en, ctl_q.ms_en, 1'b0, ctl_q.auto_inc, pc});
        RA_DIAG:  snap_d = DATA_W'({running, perr, 2'b00, pc});
        default:  snap_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctl_q  <= '0;
      snap_q <= '0;
      isir_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      snap_q <= snap_d;
      isir_q <= isir_d;
    end
  end

  assign ctl       = ctl_q;
  assign reg_rdata = isir_q ? cram_word : snap_q;
endmodule

// File: rtl/useq_maint_port.sv
module useq_maint_port
  import useq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int PC_W     = 12,
  parameter int CS_DEPTH = 2048,
  localparam int CS_AW   = $clog2(CS_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [1:0]        rsync;
  logic              srst_n;
  logic              maint_wr, pc_wr, cs_we, cs_re;
  pc_ctl_t           ctl;
  logic [PC_W-1:0]   pc_q;
  logic              run_q, hold_q, perr;
  logic [DATA_W-1:0] cram_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign srst_n = rsync[1];

  useq_regif #(.DATA_W(DATA_W), .PC_W(PC_W)) u_regif (
    .clk(clk), .srst_n(srst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pc(pc_q), .running(run_q), .hold(hold_q), .perr(perr), .cram_word(cram_word),
    .maint_wr(maint_wr), .pc_wr(pc_wr), .cs_we(cs_we), .cs_re(cs_re),
    .ctl(ctl), .reg_rdata(reg_rdata)
  );

  useq_pc_ctl #(.DATA_W(DATA_W), .PC_W(PC_W), .CS_DEPTH(CS_DEPTH)) u_pc (
    .clk(clk), .srst_n(srst_n),
    .maint_wr(maint_wr), .pc_wr(pc_wr), .wdata(reg_wdata), .auto_inc(ctl.auto_inc),
    .pc(pc_q), .running(run_q), .hold(hold_q)
  );

  useq_cstore #(.DATA_W(DATA_W), .CS_DEPTH(CS_DEPTH)) u_cs (
    .clk(clk), .srst_n(srst_n),
    .we(cs_we), .waddr(pc_q[CS_AW-1:0]), .wdata(reg_wdata),
    .re(cs_re), .raddr(pc_q[CS_AW-1:0]),
    .rword(cram_word), .perr(perr)
  );
endmodule

// File: rtl/useq_maint_chk.sv
module useq_maint_chk
  import useq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int PC_W     = 12,
  parameter int CS_DEPTH = 2048
) (
  input logic              clk,
  input logic              srst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [PC_W-1:0]   pc,
  input logic              running,
  input logic              hold
);
  localparam logic [PC_W-1:0] LAST = PC_W'(CS_DEPTH - 1);
  logic mwr, pwr;
  assign mwr = reg_wr && (reg_addr == RA_MAINT);
  assign pwr = reg_wr && (reg_addr == RA_PC);

  // R8: a held reset keeps PC at zero and the controller stopped
  a_r8_hold_clears: assert property (@(posedge clk) disable iff (!srst_n)
    hold && !mwr |=> (pc == '0) && !running);

  // R7: free run advances the PC by one with wrap
  a_r7_run_advance: assert property (@(posedge clk) disable iff (!srst_n)
    running && !hold && !reg_wr |=>
      pc == (($past(pc) == LAST) ? '0 : $past(pc) + 1'b1));

  // R6: a single step never leaves the controller running
  a_r6_step_stops: assert property (@(posedge clk) disable iff (!srst_n)
    mwr && reg_wdata[MB_START] && reg_wdata[MB_SINGLE] |=> !running);

  // R2: PC write without load enable keeps the PC
  a_r2_no_load_keeps: assert property (@(posedge clk) disable iff (!srst_n)
    pwr && !reg_wdata[PB_LOAD] && !running && !hold |=> $stable(pc));

  // R4: read data holds between read strobes
  a_r4_rdata_holds: assert property (@(posedge clk) disable iff (!srst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind useq_maint_port useq_maint_chk #(.DATA_W(DATA_W), .PC_W(PC_W), .CS_DEPTH(CS_DEPTH)) u_chk (
  .clk(clk), .srst_n(srst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pc(pc_q), .running(run_q), .hold(hold_q)
);

// File: tb/test_useq_maint_port.sv
`timescale 1ns/1ps
module test_useq_maint_port;
  localparam int DEPTH = 2048;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  useq_maint_port i_useq_maint_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 40503) ^ 16'h5A5A;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // caller is at a falling edge; returns at the next falling edge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_pc(input int p, input logic [15:0] ctl);
    wr(2'd1, ctl | 16'h2000 | 16'(p));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 rdata", reg_rdata, 16'h0);
    rd(2'd3, d); check("R1 diag", d, 16'h0);
    rd(2'd1, d); check("R1 pcreg", d, 16'h0);

    // R3 R4 sweep: write every word, then read every word back
    for (int a = 0; a < DEPTH; a++) begin
      set_pc(a, 16'h4000);
      wr(2'd2, pat(a));
    end
    for (int a = 0; a < DEPTH; a++) begin
      set_pc(a, 16'h0000);
      rd(2'd2, d); check("R4 readback", d, pat(a));
      if (a % 64 == 0) begin
        rd(2'd3, d); check("R5 perr clear", d, 16'(a));
      end
    end

    // R3 write ignored without store-write enable
    set_pc(10, 16'h0000);
    wr(2'd2, 16'hBEEF);
    rd(2'd2, d); check("R3 ignored write", d, pat(10));

    // R2 no-load PC write latches control only; R9 PC read layout
    wr(2'd1, 16'h9000 | 16'd20);
    rd(2'd1, d); check("R9 pcreg", d, 16'h9000 | 16'd10);
    rd(2'd3, d); check("R2 pc kept", d, 16'd10);
    // R2 load masks to store depth
    set_pc(12'hFFF, 16'h0000);
    rd(2'd3, d); check("R2 masked load", d, 16'h07FF);

    // R6 single step with and without auto-increment
    set_pc(5, 16'h1000);
    wr(2'd0, 16'h0006);
    rd(2'd3, d); check("R6 step inc", d, 16'd6);
    set_pc(6, 16'h0000);
    wr(2'd0, 16'h0006);
    rd(2'd3, d); check("R6 step no inc", d, 16'd6);
    rd(2'd0, d); check("R9 maint idle", d, 16'h0);

    // R7 free run with wrap, N idle cycles -> N+1 increments
    for (int n = 0; n < 6; n++) begin
      int start_pc = DEPTH - 3;
      set_pc(start_pc, 16'h0000);
      wr(2'd0, 16'h0002);
      repeat (n) @(negedge clk);
      wr(2'd0, 16'h0000);
      rd(2'd3, d); check("R7 run pc", d, 16'((start_pc + n + 1) % DEPTH));
    end
    wr(2'd0, 16'h0002);
    rd(2'd0, d); check("R9 maint running", d, 16'h0002);
    rd(2'd3, d); check("R10 diag running", d[15:14], 2'b10);
    wr(2'd0, 16'h0000);

    // R8 held reset
    set_pc(40, 16'h0000);
    wr(2'd0, 16'h0001);
    rd(2'd3, d); check("R8 pc zero", d, 16'h0);
    set_pc(33, 16'h0000);
    wr(2'd0, 16'h0003);
    rd(2'd3, d); check("R8 load and start ignored", d, 16'h0);
    rd(2'd0, d); check("R8 maint held", d, 16'h0001);
    wr(2'd0, 16'h0000);
    set_pc(33, 16'h0000);
    rd(2'd3, d); check("R10 diag after release", d, 16'd33);
    rd(2'd2, d); check("R4 word 33", d, pat(33));
    rd(2'd3, d); check("R5 perr after read", d, 16'd33);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule